// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block samples an 8-bit or 16-bit parallel camera bus and turns it into a byte stream. It runs in the system clock domain. The pixel clock and the bus inputs are sampled as ordinary synchronous inputs. A rising edge of the effective pixel clock is taken as a sample point. The effective pixel clock is the raw pixel clock, optionally inverted. At a sample point, while capture is started and the effective data-enable is high, the bus word is accepted. It is then reordered, with an optional byte swap and an optional bit reversal, and presented on `out_byte` with `out_valid`. In 16-bit mode each word yields two bytes on consecutive clock cycles.

Two counters run on the stream. The byte counter raises `eof_pulse` together with every (frame_len+1)-th byte. The line counter counts line ends and raises `line_irq` at every (line_limit+1)-th line end when the interrupt is enabled. A line end is a falling edge of the qualified data-enable or of the horizontal sync between two samples. The vertical sync can be passed through a glitch filter. A rising edge of the filtered vertical sync starts a new frame: both counters restart.

Top module: `cam_capture`

## Requirements
- R1: In 8-bit mode (`wide_mode`=0) each accepted sample produces exactly one byte. That byte is `cam_data[7:0]`, after the bit-order option, and `cam_data[15:8]` is ignored.
- R2: In 16-bit mode (`wide_mode`=1) each accepted sample produces two bytes on consecutive cycles. The first is bits [7:0] of the reordered word and the second is bits [15:8].
- R3: When `byte_swap`=1 in 16-bit mode, the word becomes {cam_data[7:0], cam_data[15:8]}. This happens before any bit reversal. In 8-bit mode `byte_swap` has no effect.
- R4: When `bit_rev`=1, output bit i of the reordered word takes input bit 7-i in 8-bit mode, and input bit 15-i of the (possibly swapped) word in 16-bit mode.
- R5: A sample is accepted only on a rising edge of (`pix_clk` XOR `pclk_inv`), only while `start`=1, and only when (`cam_de` XOR `de_inv`) is high.
- R6: `eof_pulse` is high in the same cycle as every (frame_len+1)-th output byte counted since reset or frame start. The byte count then restarts.
- R7: A line end is a 1-to-0 change of the qualified DE or of `cam_hsync` between consecutive sample points taken while started. Line ends are counted, and the (line_limit+1)-th line end restarts the count. It pulses `line_irq` for one cycle only if `line_irq_en`=1.
- R8: With `vs_filt_en`=1 the filtered vertical sync takes a new raw level only after that level has been seen on vs_thresh+1 consecutive sample points. With `vs_filt_en`=0 it follows the raw level at every sample point.
- R9: A 0-to-1 change of the filtered vertical sync restarts both the byte count and the line count, before the same sample's line end and bytes are counted.
- R10: While `rst_n`=0 and after reset, `out_valid`, `eof_pulse` and `line_irq` are low, and all counters and filter state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture enable |
| wide_mode | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| byte_swap | input | 1 | Swap the bytes of a 16-bit word |
| bit_rev | input | 1 | Reverse the bit order of the word |
| pclk_inv | input | 1 | Invert the pixel clock |
| de_inv | input | 1 | Invert the data-enable |
| vs_filt_en | input | 1 | Enable the vertical sync glitch filter |
| vs_thresh | input | 3 | Filter threshold |
| line_irq_en | input | 1 | Enable the line interrupt |
| line_limit | input | 6 | Line ends per interrupt, minus one |
| frame_len | input | 16 | Bytes per end-of-frame pulse, minus one |
| pix_clk | input | 1 | Raw pixel clock |
| cam_vsync | input | 1 | Raw vertical sync |
| cam_hsync | input | 1 | Horizontal sync |
| cam_de | input | 1 | Raw data-enable |
| cam_data | input | 16 | Camera data bus |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Output byte |
| eof_pulse | output | 1 | End-of-frame pulse, coincident with a byte |
| line_irq | output | 1 | Line interrupt pulse |

## Verification
A wrong byte counter shows up first as a misplaced `eof_pulse`, and that can stay hidden for up to frame_len+1 bytes. Short programmed lengths are therefore used, so a misplaced pulse appears within a few samples. A filter count that is off by one moves a frame restart by one sample point, and the later end-of-frame positions then shift. Glitches one sample shorter and exactly as long as the threshold expose this in the next frame. A reordering or serializer fault is visible on the very first byte after the sample, one or two cycles after the pixel clock edge.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int BUS_W  = 16;
    localparam int BYTE_W = BUS_W / 2;

    typedef struct packed {
        logic              pclk_prev;
        logic              samp_v;
        logic              de_s;
        logic              hs_s;
        logic              de_prev;
        logic              hs_prev;
        logic              wide_s;
        logic [BUS_W-1:0]  word_s;
        logic              out_v;
        logic [BYTE_W-1:0] out_b;
        logic              pend;
        logic [BYTE_W-1:0] hi_b;
    } cap_state_t;
endpackage

// File: rtl/cam_reorder.sv
module cam_reorder #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         wide,
    input  logic         swap,
    input  logic         rev,
    output logic [W-1:0] dout
);
    localparam int H = W / 2;

    logic [W-1:0] swapped;
    logic [W-1:0] rev_full;
    logic [H-1:0] rev_low;

    assign swapped = swap ? {din[H-1:0], din[W-1:H]} : din;

    for (genvar i = 0; i < W; i++) begin : g_rev_full
        assign rev_full[i] = swapped[W-1-i];
    end
    for (genvar i = 0; i < H; i++) begin : g_rev_low
        assign rev_low[i] = din[H-1-i];
    end

    always_comb begin
        if (wide) begin
            dout = rev ? rev_full : swapped;
        end else begin
            dout = {{H{1'b0}}, (rev ? rev_low : din[H-1:0])};
        end
    end
endmodule

// File: rtl/cam_vs_filter.sv
module cam_vs_filter #(
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en,
    input  logic             raw,
    input  logic             en,
    input  logic [THR_W-1:0] thresh,
    output logic             rise
);
    typedef struct packed {
        logic             lvl;
        logic             lvl_prev;
        logic [THR_W-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.lvl_prev = st_q.lvl;
        if (sample_en) begin
            if (!en) begin
                st_d.lvl = raw;
                st_d.cnt = '0;
            end else if (raw == st_q.lvl) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == thresh) begin
                st_d.lvl = raw;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.lvl & ~st_q.lvl_prev;

    // R8: bypass follows the raw level at each sample point
    p_filter_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !en) |=> (st_q.lvl == $past(raw)));
    // R8: no level change without a sample point
    p_filter_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en) |=> $stable(st_q.lvl));
endmodule

// File: rtl/cam_counters.sv
module cam_counters #(
    parameter int LEN_W  = 16,
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              line_end,
    input  logic              restart,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [LINE_W-1:0] line_limit,
    input  logic              line_irq_en,
    output logic              eof,
    output logic              line_irq
);
    typedef struct packed {
        logic [LEN_W-1:0]  bcnt;
        logic [LINE_W-1:0] lcnt;
        logic              eof;
        logic              irq;
    } cnt_t;

    cnt_t st_d, st_q;
    logic [LEN_W-1:0]  bbase;
    logic [LINE_W-1:0] lbase;

    always_comb begin
        st_d     = st_q;
        st_d.eof = 1'b0;
        st_d.irq = 1'b0;
        bbase    = restart ? '0 : st_q.bcnt;
        lbase    = restart ? '0 : st_q.lcnt;
        st_d.bcnt = bbase;
        st_d.lcnt = lbase;
        if (beat) begin
            if (bbase == frame_len) begin
                st_d.bcnt = '0;
                st_d.eof  = 1'b1;
            end else begin
                st_d.bcnt = bbase + 1'b1;
            end
        end
        if (line_end) begin
            if (lbase == line_limit) begin
                st_d.lcnt = '0;
                st_d.irq  = line_irq_en;
            end else begin
                st_d.lcnt = lbase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eof      = st_q.eof;
    assign line_irq = st_q.irq;

    // R6: after an end-of-frame the byte count has restarted
    p_eof_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eof |-> (st_q.bcnt == '0));
    // R7: interrupt only when enabled
    p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(line_irq_en));
    // R7: one-cycle pulse
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);
endmodule

// File: rtl/cam_capture.sv
module cam_capture
    import cam_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int LINE_W = 6,
    parameter int THR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_mode,
    input  logic              byte_swap,
    input  logic              bit_rev,
    input  logic              pclk_inv,
    input  logic              de_inv,
    input  logic              vs_filt_en,
    input  logic [THR_W-1:0]  vs_thresh,
    input  logic              line_irq_en,
    input  logic [LINE_W-1:0] line_limit,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              pix_clk,
    input  logic              cam_vsync,
    input  logic              cam_hsync,
    input  logic              cam_de,
    input  logic [BUS_W-1:0]  cam_data,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              eof_pulse,
    output logic              line_irq
);
    cap_state_t st_d, st_q;

    logic             pclk_eff;
    logic             take;
    logic [BUS_W-1:0] word_x;
    logic             line_end;
    logic             vs_rise;

    assign pclk_eff = pix_clk ^ pclk_inv;
    assign take     = pclk_eff & ~st_q.pclk_prev & start;

    cam_reorder #(.W(BUS_W)) u_reorder (
        .din  (cam_data),
        .wide (wide_mode),
        .swap (byte_swap),
        .rev  (bit_rev),
        .dout (word_x)
    );

    cam_vs_filter #(.THR_W(THR_W)) u_vs_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (take),
        .raw       (cam_vsync),
        .en        (vs_filt_en),
        .thresh    (vs_thresh),
        .rise      (vs_rise)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pclk_prev = pclk_eff;
        st_d.samp_v    = take;
        if (take) begin
            st_d.de_s   = cam_de ^ de_inv;
            st_d.hs_s   = cam_hsync;
            st_d.wide_s = wide_mode;
            st_d.word_s = word_x;
        end
        line_end = st_q.samp_v &
                   ((st_q.de_prev & ~st_q.de_s) | (st_q.hs_prev & ~st_q.hs_s));
        if (st_q.samp_v) begin
            st_d.de_prev = st_q.de_s;
            st_d.hs_prev = st_q.hs_s;
        end
        st_d.out_v = 1'b0;
        st_d.pend  = 1'b0;
        if (st_q.samp_v && st_q.de_s) begin
            st_d.out_v = 1'b1;
            st_d.out_b = st_q.word_s[BYTE_W-1:0];
            st_d.pend  = st_q.wide_s;
            st_d.hi_b  = st_q.word_s[BUS_W-1:BYTE_W];
        end else if (st_q.pend) begin
            st_d.out_v = 1'b1;
            st_d.out_b = st_q.hi_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cam_counters #(.LEN_W(LEN_W), .LINE_W(LINE_W)) u_counters (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (st_d.out_v),
        .line_end    (line_end),
        .restart     (vs_rise),
        .frame_len   (frame_len),
        .line_limit  (line_limit),
        .line_irq_en (line_irq_en),
        .eof         (eof_pulse),
        .line_irq    (line_irq)
    );

    assign out_valid = st_q.out_v;
    assign out_byte  = st_q.out_b;

    // R6: end-of-frame always rides on a byte
    p_eof_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |-> out_valid);
    // R1: back-to-back bytes only come from a 16-bit sample
    p_pair_only_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> st_q.wide_s);
    // R5: nothing is emitted after capture has been stopped for a while
    p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !$past(start) && !$past(start, 2) && !$past(start, 3)) |-> !out_valid);
endmodule

// File: tb/tb_cam_capture.sv
module tb_cam_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, wide_mode = 1'b0, byte_swap = 1'b0, bit_rev = 1'b0;
    logic        pclk_inv = 1'b0, de_inv = 1'b0, vs_filt_en = 1'b0, line_irq_en = 1'b0;
    logic [2:0]  vs_thresh = 3'd0;
    logic [5:0]  line_limit = 6'd0;
    logic [15:0] frame_len = 16'd0;
    logic        pix_clk = 1'b0, cam_vsync = 1'b0, cam_hsync = 1'b0, cam_de = 1'b0;
    logic [15:0] cam_data = 16'd0;
    logic        out_valid, eof_pulse, line_irq;
    logic [7:0]  out_byte;

    always #5 clk = ~clk;

    cam_capture dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
        .byte_swap(byte_swap), .bit_rev(bit_rev), .pclk_inv(pclk_inv),
        .de_inv(de_inv), .vs_filt_en(vs_filt_en), .vs_thresh(vs_thresh),
        .line_irq_en(line_irq_en), .line_limit(line_limit), .frame_len(frame_len),
        .pix_clk(pix_clk), .cam_vsync(cam_vsync), .cam_hsync(cam_hsync),
        .cam_de(cam_de), .cam_data(cam_data), .out_valid(out_valid),
        .out_byte(out_byte), .eof_pulse(eof_pulse), .line_irq(line_irq)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] got_b[$], exp_b[$];
    bit         got_e[$], exp_e[$];
    int         got_irq = 0, exp_irq = 0;
    bit         finished = 1'b0;

    bit          m_flvl, m_vs_p, m_de_p, m_hs_p;
    int          m_fcnt;
    logic [15:0] m_bcnt;
    logic [5:0]  m_lcnt;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_b.push_back(out_byte);
            got_e.push_back(eof_pulse);
        end
        if (rst_n && line_irq) got_irq++;
    end

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] xform(logic [15:0] d, bit w, bit sw, bit rv);
        logic [15:0] s, r;
        if (!w) begin
            r = 16'd0;
            for (int i = 0; i < 8; i++) r[i] = rv ? d[7-i] : d[i];
            return r;
        end
        s = sw ? {d[7:0], d[15:8]} : d;
        r = s;
        if (rv) for (int i = 0; i < 16; i++) r[i] = s[15-i];
        return r;
    endfunction

    task automatic push_byte(logic [7:0] b);
        exp_b.push_back(b);
        if (m_bcnt == frame_len) begin
            exp_e.push_back(1'b1);
            m_bcnt = 16'd0;
        end else begin
            exp_e.push_back(1'b0);
            m_bcnt = m_bcnt + 16'd1;
        end
    endtask

    task automatic pix(logic [15:0] d, bit de, bit hs, bit vs);
        logic [15:0] w;
        bit le;
        @(negedge clk);
        cam_data = d; cam_de = de ^ de_inv; cam_hsync = hs; cam_vsync = vs;
        pix_clk = 1'b1 ^ pclk_inv;
        repeat (2) @(negedge clk);
        pix_clk = 1'b0 ^ pclk_inv;
        @(negedge clk);
        if (start) begin
            if (!vs_filt_en) begin m_flvl = vs; m_fcnt = 0; end
            else if (vs == m_flvl) m_fcnt = 0;
            else if (m_fcnt == int'(vs_thresh)) begin m_flvl = vs; m_fcnt = 0; end
            else m_fcnt++;
            if (m_flvl && !m_vs_p) begin m_bcnt = 16'd0; m_lcnt = 6'd0; end
            m_vs_p = m_flvl;
            le = (m_de_p && !de) || (m_hs_p && !hs);
            m_de_p = de; m_hs_p = hs;
            if (le) begin
                if (m_lcnt == line_limit) begin
                    if (line_irq_en) exp_irq++;
                    m_lcnt = 6'd0;
                end else m_lcnt = m_lcnt + 6'd1;
            end
            if (de) begin
                w = xform(d, wide_mode, byte_swap, bit_rev);
                push_byte(w[7:0]);
                if (wide_mode) push_byte(w[15:8]);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pix_clk = pclk_inv;
        repeat (2) @(negedge clk);
        m_flvl = 0; m_vs_p = 0; m_de_p = 0; m_hs_p = 0; m_fcnt = 0;
        m_bcnt = 16'd0; m_lcnt = 6'd0;
        got_b.delete(); exp_b.delete(); got_e.delete(); exp_e.delete();
        got_irq = 0; exp_irq = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_block(string rq_bytes, string rq_eof, string rq_irq);
        int nb;
        repeat (4) @(negedge clk);
        chk(got_b.size() == exp_b.size(), {rq_bytes, " byte count"}, got_b.size(), exp_b.size());
        nb = (got_b.size() < exp_b.size()) ? got_b.size() : exp_b.size();
        for (int i = 0; i < nb; i++) begin
            if (got_b[i] !== exp_b[i]) begin
                chk(1'b0, {rq_bytes, " byte value"}, got_b[i], exp_b[i]);
                break;
            end
        end
        for (int i = 0; i < nb; i++) begin
            if (got_e[i] !== exp_e[i]) begin
                chk(1'b0, {rq_eof, " eof position"}, i, exp_e[i]);
                break;
            end
        end
        n_chk += 2;
        chk(got_irq == exp_irq, {rq_irq, " line irq count"}, got_irq, exp_irq);
        got_b.delete(); exp_b.delete(); got_e.delete(); exp_e.delete();
        got_irq = 0; exp_irq = 0;
    endtask

    task automatic set_pinv(bit v);
        @(negedge clk);
        pclk_inv = v;
        pix_clk = v;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1d5c;
        void'($urandom(seed));
        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !eof_pulse && !line_irq, "R10 outputs in reset",
            {out_valid, eof_pulse, line_irq}, 0);
        do_reset();
        chk(!out_valid && !eof_pulse && !line_irq, "R10 outputs after reset",
            {out_valid, eof_pulse, line_irq}, 0);

        // R1: 8-bit, upper bits ignored
        frame_len = 16'd100; start = 1'b1;
        pix(16'hA5B3, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 1 && got_b[0] == 8'hB3, "R1 narrow byte", got_b.size() ? got_b[0] : -1, 8'hB3);
        // R3: swap has no effect in 8-bit mode
        byte_swap = 1'b1;
        pix(16'h5AC4, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 2 && got_b[1] == 8'hC4, "R3 swap ignored narrow", got_b.size() > 1 ? got_b[1] : -1, 8'hC4);
        check_block("R1", "R6", "R7");

        // R2: wide order
        byte_swap = 1'b0; wide_mode = 1'b1;
        pix(16'h1234, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 2 && got_b[0] == 8'h34 && got_b[1] == 8'h12, "R2 wide low then high",
            got_b.size() > 1 ? {got_b[1], got_b[0]} : -1, 16'h1234);
        check_block("R2", "R6", "R7");
        // R3: swap in wide mode
        byte_swap = 1'b1;
        pix(16'h1234, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 2 && got_b[0] == 8'h12, "R3 wide swap", got_b.size() ? got_b[0] : -1, 8'h12);
        check_block("R3", "R6", "R7");
        // R4: bit reversal, wide and narrow
        byte_swap = 1'b0; bit_rev = 1'b1;
        pix(16'h1234, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 2 && got_b[0] == 8'h48 && got_b[1] == 8'h2C, "R4 wide reverse",
            got_b.size() > 1 ? {got_b[1], got_b[0]} : -1, 16'h2C48);
        check_block("R4", "R6", "R7");
        wide_mode = 1'b0;
        pix(16'hFF01, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 1 && got_b[0] == 8'h80, "R4 narrow reverse", got_b.size() ? got_b[0] : -1, 8'h80);
        check_block("R4", "R6", "R7");
        bit_rev = 1'b0;

        // R5: start low, DE low, inverted DE, inverted pixel clock
        start = 1'b0;
        pix(16'h0011, 1, 0, 0);
        start = 1'b1;
        pix(16'h0022, 0, 0, 0);
        de_inv = 1'b1;
        pix(16'h0033, 1, 0, 0);
        set_pinv(1'b1);
        pix(16'h0044, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_b.size() == 2 && got_b[0] == 8'h33, "R5 sample gating", got_b.size(), 2);
        check_block("R5", "R6", "R7");
        de_inv = 1'b0; set_pinv(1'b0);

        // R6: frame length 3 bytes
        do_reset();
        start = 1'b1; frame_len = 16'd2;
        for (int i = 0; i < 7; i++) pix(16'(i), 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_e.size() == 7 && got_e[2] && got_e[5] && !got_e[3], "R6 eof on third byte",
            got_e.size() == 7 ? {got_e[5], got_e[2]} : -1, 3);
        check_block("R6", "R6", "R7");

        // R7: line interrupt enabled / disabled
        do_reset();
        start = 1'b1; line_limit = 6'd1; line_irq_en = 1'b1;
        for (int i = 0; i < 8; i++) pix(16'h0, i % 2 == 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_irq == 2, "R7 irq every second line", got_irq, 2);
        check_block("R7", "R6", "R7");
        line_irq_en = 1'b0;
        for (int i = 0; i < 8; i++) pix(16'h0, 0, i % 2 == 0, 0);
        repeat (3) @(negedge clk);
        chk(got_irq == 0, "R7 irq disabled", got_irq, 0);
        check_block("R7", "R6", "R7");

        // R8/R9: glitch shorter than threshold ignored, long enough restarts
        do_reset();
        start = 1'b1; frame_len = 16'd3; vs_filt_en = 1'b1; vs_thresh = 3'd2;
        pix(16'h1, 1, 0, 0); pix(16'h2, 1, 0, 0);
        pix(16'h0, 0, 0, 1); pix(16'h0, 0, 0, 1); pix(16'h0, 0, 0, 0);
        pix(16'h3, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_e.size() == 3 && !got_e[2], "R8 short glitch ignored", got_e.size(), 3);
        pix(16'h4, 1, 0, 0);
        repeat (3) @(negedge clk);
        chk(got_e.size() == 4 && got_e[3], "R8 count kept across glitch", got_e.size(), 4);
        pix(16'h5, 1, 0, 0);
        pix(16'h0, 0, 0, 1); pix(16'h0, 0, 0, 1); pix(16'h0, 0, 0, 1);
        pix(16'h6, 1, 0, 1); pix(16'h7, 1, 0, 1); pix(16'h8, 1, 0, 1);
        repeat (3) @(negedge clk);
        chk(got_e.size() == 8 && !got_e[7], "R9 restart after filtered rise", got_e.size(), 8);
        pix(16'h9, 1, 0, 1);
        repeat (3) @(negedge clk);
        chk(got_e.size() == 9 && got_e[8], "R9 eof after restart", got_e.size(), 9);
        check_block("R8", "R9", "R7");

        // Random blocks: R1 R2 R3 R4 R5 R6 R7 R8 R9 against the model
        for (int blk = 0; blk < 8; blk++) begin
            do_reset();
            wide_mode = 1'($urandom); byte_swap = 1'($urandom); bit_rev = 1'($urandom);
            de_inv = 1'($urandom); vs_filt_en = 1'($urandom); vs_thresh = 3'($urandom_range(0, 3));
            line_irq_en = 1'($urandom); line_limit = 6'($urandom_range(0, 4));
            frame_len = 16'($urandom_range(0, 12)); start = 1'b1;
            set_pinv(1'($urandom));
            for (int k = 0; k < 50; k++) begin
                if (k == 35) start = 1'($urandom);
                pix(16'($urandom), ($urandom_range(0, 3) != 0), 1'($urandom),
                    ($urandom_range(0, 5) == 0));
            end
            check_block("R2 R3 R4", "R6 R9", "R7 R8");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule